// File: doc/BRIEF.md
# Multidrop Receive FIFO Gate Controller

This block sits behind the character-level receiver of a 9-bit multidrop asynchronous serial link and decides which received characters reach a small receive FIFO. A ninth bit marks each character as either an address or data. A gate opens and closes on the address characters, in a way that depends on the selected addressing mode and on two address-compare values. The FIFO can also be locked so that it takes nothing in. All of this is controlled by a one-byte receive command write. A single write may request several actions, and the block resolves any conflict between them.

The host drains the FIFO over a simple chip-select / read-strobe bus. A character is consumed only when the read strobe returns high while the chip select has stayed active for the whole low phase of the strobe. A receive interrupt flags newly stored characters. In auto-acknowledge mode a valid read clears the interrupt. Otherwise the interrupt stays up until the FIFO is empty.

Top module: `mdropRxGate`

## Requirements
- R1: After reset the FIFO is empty, the interrupt is low, the receiver is disabled, the FIFO is unlocked and the gate is closed.
- R2: While the receiver is disabled, every incoming character is dropped. A command write with bit 7 set enables the receiver. A command write with bit 7 clear does not disable it.
- R3: In normal mode (mode 0, and also mode 3), every character is stored, whether or not the gate is open and whatever the compare values hold.
- R4: In full-automatic mode (mode 2), an address character equal to either compare value opens the gate and is itself stored. Any other address character closes the gate and is dropped. Data characters are stored only while the gate is open.
- R5: In semi-automatic mode (mode 1), any address character opens the gate and is stored, whatever the compare values hold.
- R6: Command bit 3 locks the FIFO. While the FIFO is locked, incoming characters are dropped and the count does not change.
- R7: Command bit 5 (flush receiver machine) unlocks the FIFO and closes the gate.
- R8: When bit 3 arrives in the same write as bit 4 or bit 5, the lock request is ignored. The value 0xB8 therefore leaves the receiver enabled, the FIFO unlocked and the FIFO empty.
- R9: Command bit 4 empties the FIFO in one cycle. Characters are read back in arrival order: bit 8 of the read data holds the address flag and bits 7:0 hold the character.
- R10: A read consumes the head entry only on the rising edge of the read strobe, and only if the chip select was low on every sampled cycle of the low phase and at the rising edge. Any other strobe leaves the FIFO unchanged.
- R11: When the FIFO holds 4 entries, further characters are dropped and the count never exceeds 4.
- R12: Storing a character raises the pending interrupt. The output shows it only while interrupt enable is high. In auto-acknowledge mode a consuming read clears it. Without auto-acknowledge it clears when the FIFO becomes empty. A flush always clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | 0 normal, 1 semi-automatic, 2 full-automatic, 3 normal |
| addrCmp0 | input | 8 | First address-compare value |
| addrCmp1 | input | 8 | Second address-compare value |
| rxValid | input | 1 | One-cycle strobe for a received character |
| rxChar | input | 8 | Received character |
| rxIsAddr | input | 1 | Ninth bit: the character is an address |
| cmdWrite | input | 1 | Receive command write strobe |
| cmdData | input | 8 | Command byte (bit 7 enable, bit 5 flush machine, bit 4 flush FIFO, bit 3 lock) |
| intEnable | input | 1 | Receive interrupt enable |
| autoAck | input | 1 | Auto-acknowledge mode |
| csN | input | 1 | Bus chip select, active low |
| rdN | input | 1 | Bus read strobe, active low |
| rdData | output | 9 | FIFO head entry: address flag and character |
| fifoCount | output | 3 | Number of stored entries |
| rxIrq | output | 1 | Receive interrupt |
| rxEnabled | output | 1 | Receiver enabled |
| fifoLocked | output | 1 | FIFO locked |
| gateOpen | output | 1 | Address gate state |

## Verification
Address characters are sent that hit the first compare value, hit the second, or hit neither. This shows apart the full-automatic mode, the semi-automatic mode and normal mode, which ignores the gate. Combined command bytes (lock alone, lock with either flush, 0xB8) show whether the lock loses to a flush. Bus strobes with the chip select lost during the low phase or present only at the trailing edge are set against a clean strobe, which shows whether a pop needs the chip select to bracket the strobe. A long seeded random run then mixes modes, commands, bus timing and interrupt settings. At each cycle it compares the outputs with a reference model in the bench.

// File: rtl/mdropRxGate_pkg.sv
package mdropRxGate_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SEMI   = 2'd1,
    MODE_FULL   = 2'd2,
    MODE_PLAIN  = 2'd3
  } rxMode_e;

  localparam int CMD_W          = 8;
  localparam int CMD_ENABLE_BIT = 7;
  localparam int CMD_FLUSHM_BIT = 5;
  localparam int CMD_FLUSHF_BIT = 4;
  localparam int CMD_LOCK_BIT   = 3;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrobe_t;

endpackage

// File: rtl/mdropRxGateDp.sv
module mdropRxGateDp
  import mdropRxGate_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int ENT_W = DATA_W + 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fifoStrobe_t      strb,
  input  logic [ENT_W-1:0] wrEntry,
  output logic [ENT_W-1:0] rdEntry,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [ENT_W-1:0] slotView [DEPTH];

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ENT_W-1:0] slot;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot <= '0;
      end else if (strb.push && !strb.flush && wrPtr == PTR_W'(i)) begin
        slot <= wrEntry;
      end
    end
    assign slotView[i] = slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= bumpPtr(wrPtr);
      if (strb.pop)  rdPtr <= bumpPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdEntry = slotView[rdPtr];
  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |=> (count == '0));

  p_push_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.push && !strb.pop && !strb.flush) |=> (count == CNT_W'($past(count) + 1'b1)));

endmodule

// File: rtl/mdropRxGateCtrl.sv
module mdropRxGateCtrl
  import mdropRxGate_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        modeSel,
  input  logic [DATA_W-1:0] addrCmp0,
  input  logic [DATA_W-1:0] addrCmp1,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxChar,
  input  logic              rxIsAddr,
  input  logic              cmdWrite,
  input  logic [CMD_W-1:0]  cmdData,
  input  logic              intEnable,
  input  logic              autoAck,
  input  logic              csN,
  input  logic              rdN,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  output fifoStrobe_t       strb,
  output logic              rxEnabled,
  output logic              fifoLocked,
  output logic              gateOpen,
  output logic              rxIrq
);

  rxMode_e mode;
  logic    cmdEnable, flushMach, flushFifo, lockReq;
  logic    autoMode, addrHit, addrOpens, charArrives, passGate;
  logic    rdPrev, csHeld, popEdge, irqPending;

  assign mode = rxMode_e'(modeSel);

  // command decode; a flush in the same write overrides the lock
  assign cmdEnable = cmdWrite && cmdData[CMD_ENABLE_BIT];
  assign flushMach = cmdWrite && cmdData[CMD_FLUSHM_BIT];
  assign flushFifo = cmdWrite && cmdData[CMD_FLUSHF_BIT];
  assign lockReq   = cmdWrite && cmdData[CMD_LOCK_BIT] && !flushMach && !flushFifo;

  // address gate
  assign autoMode    = (mode == MODE_SEMI) || (mode == MODE_FULL);
  assign addrHit     = (rxChar == addrCmp0) || (rxChar == addrCmp1);
  assign addrOpens   = (mode == MODE_SEMI) || ((mode == MODE_FULL) && addrHit);
  assign charArrives = rxValid && rxEnabled;

  always_comb begin
    if (!autoMode)     passGate = 1'b1;
    else if (rxIsAddr) passGate = addrOpens;
    else               passGate = gateOpen;
  end

  // bus strobe: pop on trailing edge of rdN with csN held throughout
  assign popEdge = rdN && !rdPrev && csHeld && !csN;

  always_comb begin
    strb.flush = flushFifo;
    strb.push  = charArrives && passGate && !fifoLocked && !fifoFull && !flushFifo;
    strb.pop   = popEdge && !fifoEmpty && !flushFifo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPrev <= 1'b1;
      csHeld <= 1'b0;
    end else begin
      rdPrev <= rdN;
      if (!rdN) csHeld <= rdPrev ? !csN : (csHeld && !csN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxEnabled  <= 1'b0;
      fifoLocked <= 1'b0;
      gateOpen   <= 1'b0;
    end else begin
      if (cmdEnable) rxEnabled <= 1'b1;
      if (flushMach)    fifoLocked <= 1'b0;
      else if (lockReq) fifoLocked <= 1'b1;
      if (flushMach) gateOpen <= 1'b0;
      else if (charArrives && autoMode && rxIsAddr) gateOpen <= addrOpens;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqPending <= 1'b0;
    end else if (flushFifo) begin
      irqPending <= 1'b0;
    end else if (strb.push) begin
      irqPending <= 1'b1;
    end else if (strb.pop && (autoAck || fifoCount == CNT_W'(1))) begin
      irqPending <= 1'b0;
    end
  end

  assign rxIrq = irqPending && intEnable;

  p_irq_has_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrq |-> (fifoCount != '0));

  p_unlock_on_flushm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flushMach |=> (!fifoLocked && !gateOpen));

  p_lock_loses_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrite && cmdData[CMD_LOCK_BIT] && cmdData[CMD_FLUSHM_BIT]) |=> !fifoLocked);

  p_miss_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValid && rxEnabled && rxIsAddr && modeSel == 2'd2 && !cmdWrite &&
     rxChar != addrCmp0 && rxChar != addrCmp1) |=> !gateOpen);

  p_pop_needs_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> (!csN && rdN && !$past(rdN)));

  p_locked_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifoLocked |-> !strb.push);

endmodule

// File: rtl/mdropRxGate.sv
module mdropRxGate
  import mdropRxGate_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        modeSel,
  input  logic [DATA_W-1:0] addrCmp0,
  input  logic [DATA_W-1:0] addrCmp1,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxChar,
  input  logic              rxIsAddr,
  input  logic              cmdWrite,
  input  logic [7:0]        cmdData,
  input  logic              intEnable,
  input  logic              autoAck,
  input  logic              csN,
  input  logic              rdN,
  output logic [DATA_W:0]   rdData,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              rxIrq,
  output logic              rxEnabled,
  output logic              fifoLocked,
  output logic              gateOpen
);

  fifoStrobe_t strb;
  logic        fifoFull, fifoEmpty;

  mdropRxGateCtrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel),
    .addrCmp0(addrCmp0), .addrCmp1(addrCmp1),
    .rxValid(rxValid), .rxChar(rxChar), .rxIsAddr(rxIsAddr),
    .cmdWrite(cmdWrite), .cmdData(cmdData),
    .intEnable(intEnable), .autoAck(autoAck), .csN(csN), .rdN(rdN),
    .fifoCount(fifoCount), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .strb(strb), .rxEnabled(rxEnabled), .fifoLocked(fifoLocked),
    .gateOpen(gateOpen), .rxIrq(rxIrq)
  );

  mdropRxGateDp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .wrEntry({rxIsAddr, rxChar}), .rdEntry(rdData),
    .count(fifoCount), .full(fifoFull), .empty(fifoEmpty)
  );

endmodule

// File: tb/mdropRxGate_bench.sv
module mdropRxGate_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] modeSel;
  logic [7:0] addrCmp0, addrCmp1, rxChar, cmdData;
  logic       rxValid, rxIsAddr, cmdWrite, intEnable, autoAck, csN, rdN;
  logic [8:0] rdData;
  logic [2:0] fifoCount;
  logic       rxIrq, rxEnabled, fifoLocked, gateOpen;

  int  nTests = 0;
  int  nFails = 0;
  bit  done   = 0;

  // reference model state
  bit       mEn, mLock, mGate, mIrq, mRdPrev, mCsHeld;
  logic [8:0] mQ [4];
  int       mCnt;

  always #2 clk = ~clk;

  mdropRxGate u_mdropRxGate (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel),
    .addrCmp0(addrCmp0), .addrCmp1(addrCmp1),
    .rxValid(rxValid), .rxChar(rxChar), .rxIsAddr(rxIsAddr),
    .cmdWrite(cmdWrite), .cmdData(cmdData),
    .intEnable(intEnable), .autoAck(autoAck), .csN(csN), .rdN(rdN),
    .rdData(rdData), .fifoCount(fifoCount), .rxIrq(rxIrq),
    .rxEnabled(rxEnabled), .fifoLocked(fifoLocked), .gateOpen(gateOpen)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mEn = 0; mLock = 0; mGate = 0; mIrq = 0; mRdPrev = 1; mCsHeld = 0; mCnt = 0;
    for (int i = 0; i < 4; i++) mQ[i] = '0;
  endtask

  task automatic modelUpdate();
    bit flushM, flushF, lockR, arrive, autoM, hit, opens, pass, push, popE, pop;
    int oldCnt;
    flushM = cmdWrite && cmdData[5];
    flushF = cmdWrite && cmdData[4];
    lockR  = cmdWrite && cmdData[3] && !flushM && !flushF;
    arrive = rxValid && mEn;
    autoM  = (modeSel == 2'd1) || (modeSel == 2'd2);
    hit    = (rxChar == addrCmp0) || (rxChar == addrCmp1);
    opens  = (modeSel == 2'd1) || ((modeSel == 2'd2) && hit);
    pass   = !autoM ? 1'b1 : (rxIsAddr ? opens : mGate);
    push   = arrive && pass && !mLock && (mCnt < 4) && !flushF;
    popE   = rdN && !mRdPrev && mCsHeld && !csN;
    pop    = popE && (mCnt > 0) && !flushF;
    oldCnt = mCnt;
    if (!rdN) mCsHeld = mRdPrev ? !csN : (mCsHeld && !csN);
    mRdPrev = rdN;
    if (flushF) mCnt = 0;
    else begin
      if (pop) begin
        for (int i = 0; i < 3; i++) mQ[i] = mQ[i+1];
        mCnt--;
      end
      if (push) begin
        mQ[mCnt] = {rxIsAddr, rxChar};
        mCnt++;
      end
    end
    if (flushF) mIrq = 0;
    else if (push) mIrq = 1;
    else if (pop && (autoAck || oldCnt == 1)) mIrq = 0;
    if (flushM) mGate = 0;
    else if (arrive && autoM && rxIsAddr) mGate = opens;
    if (flushM) mLock = 0;
    else if (lockR) mLock = 1;
    if (cmdWrite && cmdData[7]) mEn = 1;
  endtask

  task automatic compareAll();
    check("R9 count", 16'(fifoCount), 16'(mCnt));
    check("R12 irq", 16'(rxIrq), 16'(mIrq && intEnable));
    check("R6 locked", 16'(fifoLocked), 16'(mLock));
    check("R2 enabled", 16'(rxEnabled), 16'(mEn));
    check("R4 gate", 16'(gateOpen), 16'(mGate));
    if (mCnt > 0) check("R9 head", 16'(rdData), 16'(mQ[0]));
  endtask

  task automatic step();
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    compareAll();
  endtask

  task automatic sendChar(input logic [7:0] c, input bit isAddr);
    rxValid = 1; rxChar = c; rxIsAddr = isAddr;
    step();
    rxValid = 0;
  endtask

  task automatic sendCmd(input logic [7:0] v);
    cmdWrite = 1; cmdData = v;
    step();
    cmdWrite = 0; cmdData = 8'h00;
  endtask

  task automatic busRead(input bit csLow, input bit csAtRise);
    csN = !csLow; rdN = 1; step();
    rdN = 0; step(); step();
    rdN = 1; csN = !csAtRise; step();
    csN = 1; step();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFails++; nTests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; modeSel = 2'd2; addrCmp0 = 8'h5A; addrCmp1 = 8'h3C;
    rxValid = 0; rxChar = 0; rxIsAddr = 0; cmdWrite = 0; cmdData = 0;
    intEnable = 1; autoAck = 0; csN = 1; rdN = 1;
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", 16'(fifoCount), 16'd0);
    check("R1 irq", 16'(rxIrq), 16'd0);
    check("R1 enabled", 16'(rxEnabled), 16'd0);
    check("R1 locked", 16'(fifoLocked), 16'd0);
    check("R1 gate", 16'(gateOpen), 16'd0);

    // R2 disabled receiver drops characters
    modeSel = 2'd0;
    sendChar(8'h11, 0);
    check("R2 dropped while disabled", 16'(fifoCount), 16'd0);
    sendCmd(8'h80);
    check("R2 enable", 16'(rxEnabled), 16'd1);
    sendCmd(8'h00);
    check("R2 no disable", 16'(rxEnabled), 16'd1);

    // R3 normal mode stores all; R9 order and flag
    sendChar(8'h11, 0);
    sendChar(8'h22, 1);
    check("R3 count", 16'(fifoCount), 16'd2);
    check("R9 head first", 16'(rdData), 16'h011);
    check("R12 irq raised", 16'(rxIrq), 16'd1);
    busRead(1, 1);
    check("R9 head second", 16'(rdData), 16'h122);
    check("R12 irq held no autoack", 16'(rxIrq), 16'd1);
    busRead(1, 1);
    check("R12 irq clear on empty", 16'(rxIrq), 16'd0);

    // R4 full automatic
    modeSel = 2'd2;
    sendChar(8'h77, 1);
    check("R4 miss dropped", 16'(fifoCount), 16'd0);
    sendChar(8'h01, 0);
    check("R4 data closed dropped", 16'(fifoCount), 16'd0);
    sendChar(8'h3C, 1);
    check("R4 hit cmp1 opens", 16'(gateOpen), 16'd1);
    sendChar(8'h02, 0);
    check("R4 data stored", 16'(fifoCount), 16'd2);
    sendChar(8'h99, 1);
    check("R4 miss closes", 16'(gateOpen), 16'd0);
    sendCmd(8'h10);
    check("R9 flush one cycle", 16'(fifoCount), 16'd0);
    sendChar(8'h5A, 1);
    check("R4 hit cmp0 stored", 16'(rdData), 16'h15A);
    sendCmd(8'h10);

    // R5 semi automatic
    modeSel = 2'd1;
    sendChar(8'h99, 1);
    check("R5 any addr opens", 16'(gateOpen), 16'd1);
    sendChar(8'h03, 0);
    check("R5 count", 16'(fifoCount), 16'd2);
    sendCmd(8'h10);

    // R11 full, R10 bus strobes, R12 auto-ack
    modeSel = 2'd0;
    for (int i = 1; i <= 5; i++) sendChar(8'hA0 + 8'(i), 0);
    check("R11 capped", 16'(fifoCount), 16'd4);
    check("R11 head", 16'(rdData), 16'h0A1);
    busRead(0, 1);
    check("R10 cs only at rise", 16'(fifoCount), 16'd4);
    busRead(1, 0);
    check("R10 cs lost at rise", 16'(fifoCount), 16'd4);
    busRead(1, 1);
    check("R10 good read", 16'(fifoCount), 16'd3);
    check("R10 next head", 16'(rdData), 16'h0A2);
    autoAck = 1;
    busRead(1, 1);
    check("R12 autoack clears", 16'(rxIrq), 16'd0);
    check("R12 data remains", 16'(fifoCount), 16'd2);
    autoAck = 0;
    sendCmd(8'h90);

    // R6 lock, R7 flush machine
    modeSel = 2'd2;
    sendChar(8'h5A, 1);
    sendCmd(8'h08);
    check("R6 locked", 16'(fifoLocked), 16'd1);
    sendChar(8'h44, 0);
    check("R6 dropped while locked", 16'(fifoCount), 16'd1);
    sendCmd(8'h20);
    check("R7 unlocked", 16'(fifoLocked), 16'd0);
    check("R7 gate closed", 16'(gateOpen), 16'd0);
    sendChar(8'h45, 0);
    check("R4 closed after flush", 16'(fifoCount), 16'd1);

    // R8 conflicts
    sendCmd(8'h08);
    sendCmd(8'hB8);
    check("R8 B8 unlocked", 16'(fifoLocked), 16'd0);
    check("R8 B8 enabled", 16'(rxEnabled), 16'd1);
    check("R8 B8 empty", 16'(fifoCount), 16'd0);
    sendCmd(8'h18);
    check("R8 flushf beats lock", 16'(fifoLocked), 16'd0);
    sendCmd(8'h28);
    check("R8 flushm beats lock", 16'(fifoLocked), 16'd0);

    // R12 interrupt enable gating
    modeSel = 2'd0; intEnable = 0;
    sendChar(8'h66, 0);
    check("R12 masked", 16'(rxIrq), 16'd0);
    intEnable = 1;
    step();
    check("R12 unmasked", 16'(rxIrq), 16'd1);
    sendCmd(8'h10);

    // constrained random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 250 == 0) modeSel = 2'($urandom_range(0, 3));
      if (cyc % 97 == 0) begin
        autoAck = 1'($urandom_range(0, 1));
        intEnable = ($urandom_range(0, 5) != 0);
      end
      rxValid  = ($urandom_range(0, 2) == 0);
      rxIsAddr = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 3))
        0: rxChar = addrCmp0;
        1: rxChar = addrCmp1;
        default: rxChar = 8'($urandom);
      endcase
      cmdWrite = ($urandom_range(0, 29) == 0);
      cmdData  = 8'($urandom);
      rdN = ($urandom_range(0, 1) == 0);
      csN = ($urandom_range(0, 6) == 0);
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule